// File: doc/BRIEF.md
# Carry-Save Redundant Adder

This block adds two numbers held in redundant binary form without any carry travelling along the word. Each digit of a number has the value 0, 1 or 2 and is carried as a pair of bits, a sum bit and a carry bit. Both bits have the weight of their own position, so the digit is their arithmetic total. A single value can be written in several ways: the digit strings 0 2 1 1 0 and 1 0 1 0 2 both stand for 22.

The first operand is always in this redundant form. The second is chosen by `mode_i`. It is either a plain binary word or another redundant number. In plain mode a single row of full adders folds the operand's bit into each digit. In redundant mode two rows of full adders reduce the four bits at each position to one digit. In both modes the carry from a position goes only to the next position up. The carries that leave the top digit are counted on `top_carry_o`. A separate output turns the redundant result into an ordinary binary word with a carry-propagate adder, so the result can be read as a plain number.

The block is purely combinational. It is meant to sit inside accumulation loops and multiplier trees, where only the final value needs a full carry-propagate step.

Top module: `csa_redundant_add`

## Requirements
- R1: Digit i of an operand or of the result has the value sum_bit[i] + carry_bit[i], in {0,1,2}. The value of the number is the total of digit(i)·2^i over all DIGITS positions.
- R2: With `mode_i` = 0 (plain), the value of the result plus `top_carry_o`·2^DIGITS equals value(x) + `y_sum_i`, where `y_sum_i` is read as an unsigned binary word.
- R3: With `mode_i` = 1 (redundant), the value of the result plus `top_carry_o`·2^DIGITS equals value(x) + value(y), where y is formed from `y_sum_i` and `y_cry_i`.
- R4: With `mode_i` = 0, `y_cry_i` has no effect on any output.
- R5: Result digit i depends only on input positions i-2 to i. Changing an input bit at position j leaves every result digit below j unchanged.
- R6: `top_carry_o` is an unsigned count of the carries leaving the top digit. It is 0 to 2 in redundant mode and never exceeds 1 in plain mode.
- R7: `top_carry_o` is 0 whenever the arithmetic total of the inputs is below 2^DIGITS.
- R8: `bin_o` equals the arithmetic total of the inputs modulo 2^(DIGITS+1).
- R9: Position 0 receives a constant zero carry, so `r_cry_o[0]` is always 0.
- R10: When all operand inputs are zero, every output is zero in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0: second operand is plain binary; 1: second operand is redundant |
| x_sum_i | input | DIGITS | Sum bits of the first operand |
| x_cry_i | input | DIGITS | Carry bits of the first operand |
| y_sum_i | input | DIGITS | Plain binary second operand, or the sum bits of a redundant one |
| y_cry_i | input | DIGITS | Carry bits of the second operand; used only when mode_i = 1 |
| r_sum_o | output | DIGITS | Sum bits of the redundant result |
| r_cry_o | output | DIGITS | Carry bits of the redundant result |
| top_carry_o | output | 2 | Number of carries leaving the top digit |
| bin_o | output | DIGITS+1 | Result converted to plain binary, modulo 2^(DIGITS+1) |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus and no register lies on any path. The bench applies each input set just after a rising clock edge and reads all outputs at the following falling edge, half a period later, when the logic has settled. For a four-digit build it sweeps every input combination in redundant mode and every combination in plain mode. In plain mode each combination is applied twice, with opposite `y_cry_i`, and the two sets of outputs are compared.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_REDUN = 1'b1
  } add_mode_e;

  localparam int unsigned TOP_CNT_W = 2;
endpackage

// File: rtl/csa_fa_row.sv
// Row of independent full adders; cry_o[i] carries weight 2^(i+1).
module csa_fa_row #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign sum_o[i] = p ^ c_i[i];
    assign cry_o[i] = (a_i[i] & b_i[i]) | (p & c_i[i]);
  end
endmodule

// File: rtl/csa_resolve.sv
// Carry-propagate conversion of a redundant word plus top carries to binary.
module csa_resolve #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] cry_i,
  input  logic [1:0]   top_i,
  output logic [W:0]   val_o
);
  logic [W:0] c;

  assign c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_rip
    logic g, p;
    assign g        = sum_i[i] & cry_i[i];
    assign p        = sum_i[i] ^ cry_i[i];
    assign val_o[i] = p ^ c[i];
    assign c[i+1]   = g | (p & c[i]);
  end
  // weight 2^W: ripple carry plus top count, reduced mod 2
  assign val_o[W] = c[W] ^ top_i[0];
endmodule

// File: rtl/csa_redundant_add.sv
module csa_redundant_add
  import csa_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic              mode_i,
  input  logic [DIGITS-1:0] x_sum_i,
  input  logic [DIGITS-1:0] x_cry_i,
  input  logic [DIGITS-1:0] y_sum_i,
  input  logic [DIGITS-1:0] y_cry_i,
  output logic [DIGITS-1:0] r_sum_o,
  output logic [DIGITS-1:0] r_cry_o,
  output logic [1:0]        top_carry_o,
  output logic [DIGITS:0]   bin_o
);
  localparam int unsigned W  = DIGITS;
  localparam int unsigned TW = W + 2;

  add_mode_e mode;
  assign mode = add_mode_e'(mode_i);

  logic [W-1:0] s1, c1, s2, c2, c1_up, yc_gated;

  csa_fa_row #(.W(W)) u_row_a (
    .a_i   (x_sum_i),
    .b_i   (x_cry_i),
    .c_i   (y_sum_i),
    .sum_o (s1),
    .cry_o (c1)
  );

  // position 0 receives a constant zero carry
  assign c1_up    = {c1[W-2:0], 1'b0};
  assign yc_gated = (mode == MODE_REDUN) ? y_cry_i : '0;

  csa_fa_row #(.W(W)) u_row_b (
    .a_i   (s1),
    .b_i   (yc_gated),
    .c_i   (c1_up),
    .sum_o (s2),
    .cry_o (c2)
  );

  always_comb begin
    if (mode == MODE_REDUN) begin
      r_sum_o     = s2;
      r_cry_o     = {c2[W-2:0], 1'b0};
      top_carry_o = {c1[W-1] & c2[W-1], c1[W-1] ^ c2[W-1]};
    end else begin
      r_sum_o     = s1;
      r_cry_o     = c1_up;
      top_carry_o = {1'b0, c1[W-1]};
    end
  end

  csa_resolve #(.W(W)) u_resolve (
    .sum_i (r_sum_o),
    .cry_i (r_cry_o),
    .top_i (top_carry_o),
    .val_o (bin_o)
  );

  logic [TW-1:0] in_tot, out_tot;
  always_comb begin
    in_tot  = {2'b00, x_sum_i} + {2'b00, x_cry_i} + {2'b00, y_sum_i}
            + {2'b00, yc_gated};
    out_tot = {2'b00, r_sum_o} + {2'b00, r_cry_o} + {top_carry_o, {W{1'b0}}};
  end

  always_comb begin
    // R2 R3
    value_keep_chk: assert (out_tot == in_tot);
    // R6
    plain_top_chk: assert (mode == MODE_REDUN || !top_carry_o[1]);
    // R7
    small_sum_chk: assert (in_tot >= TW'(1) << W || top_carry_o == 2'b00);
    // R8
    conv_chk: assert (bin_o == in_tot[W:0]);
    // R9
    low_carry_chk: assert (!r_cry_o[0]);
  end
endmodule

// File: tb/csa_redundant_add_tb.sv
module csa_redundant_add_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 4;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         mode;
  logic [D-1:0] xs, xc, ys, yc, rs, rc;
  logic [1:0]   top;
  logic [D:0]   bin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  csa_redundant_add #(.DIGITS(D)) u_dut (
    .mode_i      (mode),
    .x_sum_i     (xs),
    .x_cry_i     (xc),
    .y_sum_i     (ys),
    .y_cry_i     (yc),
    .r_sum_o     (rs),
    .r_cry_o     (rc),
    .top_carry_o (top),
    .bin_o       (bin)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [D-1:0] a, b, c, d);
    @(posedge clk);
    mode = m; xs = a; xc = b; ys = c; yc = d;
    @(negedge clk);
  endtask

  function automatic int in_total();
    return int'(xs) + int'(xc) + int'(ys) + (mode ? int'(yc) : 0);
  endfunction

  task automatic check_vec();
    int tot, rv;
    tot = in_total();
    rv  = int'(rs) + int'(rc) + int'(top) * (1 << D);
    chk(rv == tot, mode ? "R3 R1 value" : "R2 R1 value", rv, tot);
    chk(int'(bin) == tot % (1 << (D+1)), "R8 conversion", int'(bin), tot % (1 << (D+1)));
    chk(rc[0] == 1'b0, "R9 low carry", int'(rc[0]), 0);
    if (!mode) chk(top <= 2'd1, "R6 plain top count", int'(top), 1);
    if (tot < (1 << D)) chk(top == 2'd0, "R7 small sum", int'(top), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mode = 1'b0; xs = '0; xc = '0; ys = '0; yc = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R10 zero inputs in both modes
    for (int m = 0; m < 2; m++) begin
      apply(m[0], '0, '0, '0, '0);
      chk(rs == '0 && rc == '0 && top == '0 && bin == '0, "R10 zero",
          int'({rs, rc, top, bin}), 0);
    end

    // R3 exhaustive redundant mode
    for (int v = 0; v < (1 << (4*D)); v++) begin
      apply(1'b1, v[D-1:0], v[2*D-1:D], v[3*D-1:2*D], v[4*D-1:3*D]);
      check_vec();
      if (xs == '1 && xc == '1 && ys == '1 && yc == '1)
        chk(top == 2'd2, "R6 double top carry", int'(top), 2);
    end

    // R2 exhaustive plain mode, R4 y_cry ignored
    for (int v = 0; v < (1 << (3*D)); v++) begin
      logic [D-1:0] s0, c0;
      logic [1:0]   t0;
      logic [D:0]   b0;
      apply(1'b0, v[D-1:0], v[2*D-1:D], v[3*D-1:2*D], '0);
      check_vec();
      s0 = rs; c0 = rc; t0 = top; b0 = bin;
      apply(1'b0, v[D-1:0], v[2*D-1:D], v[3*D-1:2*D], '1);
      chk(rs == s0 && rc == c0 && top == t0 && bin == b0, "R4 y_cry ignored",
          int'({rs, rc, top, bin}), int'({s0, c0, t0, b0}));
    end

    // R5 locality: flipping position j leaves digits below j intact
    for (int n = 0; n < 200; n++) begin
      logic [D-1:0] a, b, c, d, s0, c0, msk;
      logic         m;
      {a, b, c, d} = 16'($urandom);
      m = 1'($urandom);
      apply(m, a, b, c, d);
      s0 = rs; c0 = rc;
      for (int j = 0; j < D; j++) begin
        msk = D'((1 << j) - 1);
        apply(m, a ^ D'(1 << j), b, c, d ^ D'(1 << j));
        chk(((rs ^ s0) & msk) == '0 && ((rc ^ c0) & msk) == '0, "R5 locality",
            int'({rs & msk, rc & msk}), int'({s0 & msk, c0 & msk}));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule